// File: doc/BRIEF.md
# Circular Message-Frame Queue Manager

The block keeps four circular queues of 32-bit frame addresses in one contiguous memory region. A single base register and a size field place them back to back: inbound free, then inbound post, then outbound free, then outbound post. For each queue the block holds a head pointer and a tail pointer. The local processor sees all eight pointers, the base and a control register as read/write registers.

A host reaches the queues through two ports, inbound and outbound. The direction of an access picks the queue:
- An inbound read takes the next inbound free entry. An inbound write appends to inbound post.
- An outbound read takes the next outbound post entry. An outbound write appends to outbound free.

An empty read returns all ones. A push into a full queue is dropped, and for the two host-filled queues it raises a sticky overflow flag. Entries move through a simple word request interface to memory that is held until acknowledged.

The local processor fills and drains its side of each queue itself: it moves words in memory and then writes the head or tail register.

Top module: `frame_queue_mgr`

## Requirements
- R1: A base write (register 0) stores only bits 31:20; bits 19:0 read back as zero, and every memory request address has bits 31:20 equal to the base.
- R2: Queue k (0 inbound free, 1 inbound post, 2 outbound free, 3 outbound post) starts at base + k*(size<<11). Reset, a base write, and a control write that changes the size each set every head and tail to its queue's start. Control register 1 holds enable at bit 0 and size at bits 5:1, and resets to size 1 with enable clear. Head of queue k is register 2+2k and tail is register 3+2k.
- R3: A pointer moved by a host access advances by 4 and wraps to its queue's start when it reaches start + (size<<11).
- R4: An inbound read of a non-empty inbound free queue returns the word at its tail and advances that tail.
- R5: An inbound write to a non-full inbound post queue stores the data at its head and advances that head.
- R6: An outbound read pops outbound post at its tail. An outbound write pushes outbound free at its head.
- R7: A read of an empty queue (head equal to tail) returns 0xFFFFFFFF, issues no memory request and moves no pointer.
- R8: A push is full when the advanced head would equal the tail. The push is then dropped, with no memory write and no pointer change. For inbound post it sets inPostOvf; for outbound free it sets outFreeOvf. Both flags hold until reset or a write to register 0 or 1.
- R9: While enable is clear, port reads return 0xFFFFFFFF and port writes change nothing.
- R10: outPostPending is high exactly while the outbound post head differs from its tail.
- R11: memReq, memAddr and memWe hold steady until memAck. hostDone is a one-cycle pulse, and hostRdData is valid with it.
- R12: Pointer registers read back what was written. When a host access moves the same pointer in the same cycle, the host update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Local register write strobe |
| regAddr | input | 4 | Local register select |
| regWrData | input | 32 | Local register write data |
| regRdData | output | 32 | Local register read data (combinational) |
| hostValid | input | 1 | Host access request, held until hostDone |
| hostWrite | input | 1 | 1 = push, 0 = pop |
| hostPort | input | 1 | 0 = inbound port, 1 = outbound port |
| hostWrData | input | 32 | Frame address to push |
| hostRdData | output | 32 | Popped frame address or all ones |
| hostDone | output | 1 | Host access complete |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory request accepted |
| outPostPending | output | 1 | Outbound post queue not empty |
| inPostOvf | output | 1 | Inbound post overflow, sticky |
| outFreeOvf | output | 1 | Outbound free overflow, sticky |

## Verification
A corrupted pointer shows at once in the register readback. It also shows on the first memory request aimed at the wrong queue address, or as a wrong all-ones answer on the next host read. A broken wrap shows in the very access that crosses the queue end: the pointer reads back past the region instead of at the queue start. A wrong full or empty decision shows in the same host access, as an unexpected memory request, a missing memory request or a wrong overflow flag, all visible before hostDone.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int NUM_Q = 4;
  localparam logic [1:0] Q_IN_FREE  = 2'd0;
  localparam logic [1:0] Q_IN_POST  = 2'd1;
  localparam logic [1:0] Q_OUT_FREE = 2'd2;
  localparam logic [1:0] Q_OUT_POST = 2'd3;

  typedef struct packed {
    logic       popTail;
    logic       pushHead;
    logic       setOvf;
    logic [1:0] qSel;
  } qmStrobe_t;
endpackage

// File: rtl/qm_datapath.sv
module qm_datapath
  import qm_pkg::*;
#(
  parameter int SZ_W      = 5,
  parameter int SZ_SHIFT  = 11,
  parameter int BASE_LSB  = 20,
  parameter int RESET_SZ  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  qmStrobe_t   strb,
  output logic        qEmpty,
  output logic        qFull,
  output logic [31:0] qHead,
  output logic [31:0] qTail,
  output logic        enable,
  output logic [31:0] baseAddr,
  output logic        inPostOvf,
  output logic        outFreeOvf,
  output logic        outPostPending
);
  localparam logic [31:0] BASE_MASK = ~((32'd1 << BASE_LSB) - 32'd1);

  logic [31:0]     baseR;
  logic [SZ_W-1:0] sizeR;
  logic            enR;
  logic            inOvfR, outOvfR;
  logic [31:0]     qBytes, newBase, newBytes;
  logic [SZ_W-1:0] newSize;
  logic            wrBase, wrCtrl, reinit;
  logic [31:0]     headQ [NUM_Q];
  logic [31:0]     tailQ [NUM_Q];
  logic [31:0]     nextHead [NUM_Q];

  assign wrBase   = regWe && (regAddr == 4'd0);
  assign wrCtrl   = regWe && (regAddr == 4'd1);
  assign qBytes   = 32'(sizeR) << SZ_SHIFT;
  assign newBase  = wrBase ? (regWrData & BASE_MASK) : baseR;
  assign newSize  = wrCtrl ? regWrData[SZ_W:1] : sizeR;
  assign newBytes = 32'(newSize) << SZ_SHIFT;
  assign reinit   = wrBase || (wrCtrl && (newSize != sizeR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR   <= '0;
      sizeR   <= SZ_W'(RESET_SZ);
      enR     <= 1'b0;
      inOvfR  <= 1'b0;
      outOvfR <= 1'b0;
    end else begin
      baseR <= newBase;
      sizeR <= newSize;
      if (wrCtrl) enR <= regWrData[0];
      if (wrBase || wrCtrl) begin
        inOvfR  <= 1'b0;
        outOvfR <= 1'b0;
      end else if (strb.setOvf) begin
        if (strb.qSel == Q_IN_POST)  inOvfR  <= 1'b1;
        if (strb.qSel == Q_OUT_FREE) outOvfR <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_Q; k++) begin : g_queue
    logic [31:0] startA, endA, headR, tailR, headInc, tailInc, nextTail;
    logic [31:0] resetStart, newStart;
    logic        selHere;
    assign startA     = baseR + 32'(k) * qBytes;
    assign endA       = startA + qBytes;
    assign resetStart = 32'(k) * (32'(RESET_SZ) << SZ_SHIFT);
    assign newStart   = newBase + 32'(k) * newBytes;
    assign headInc    = headR + 32'd4;
    assign tailInc    = tailR + 32'd4;
    assign nextHead[k] = (headInc == endA) ? startA : headInc;
    assign nextTail    = (tailInc == endA) ? startA : tailInc;
    assign selHere    = (strb.qSel == 2'(k));
    assign headQ[k]   = headR;
    assign tailQ[k]   = tailR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        headR <= resetStart;
        tailR <= resetStart;
      end else if (reinit) begin
        headR <= newStart;
        tailR <= newStart;
      end else begin
        if (strb.pushHead && selHere)                    headR <= nextHead[k];
        else if (regWe && regAddr == 4'(2 + 2 * k))      headR <= regWrData;
        if (strb.popTail && selHere)                     tailR <= nextTail;
        else if (regWe && regAddr == 4'(3 + 2 * k))      tailR <= regWrData;
      end
    end
  end

  assign qHead  = headQ[strb.qSel];
  assign qTail  = tailQ[strb.qSel];
  assign qEmpty = (qHead == qTail);
  assign qFull  = (nextHead[strb.qSel] == qTail);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      4'd0: regRdData = baseR;
      4'd1: regRdData = {{(31 - SZ_W){1'b0}}, sizeR, enR};
      4'd2: regRdData = headQ[0];
      4'd3: regRdData = tailQ[0];
      4'd4: regRdData = headQ[1];
      4'd5: regRdData = tailQ[1];
      4'd6: regRdData = headQ[2];
      4'd7: regRdData = tailQ[2];
      4'd8: regRdData = headQ[3];
      4'd9: regRdData = tailQ[3];
      default: regRdData = '0;
    endcase
  end

  assign enable         = enR;
  assign baseAddr       = baseR;
  assign inPostOvf      = inOvfR;
  assign outFreeOvf     = outOvfR;
  assign outPostPending = (headQ[Q_OUT_POST] != tailQ[Q_OUT_POST]);
endmodule

// File: rtl/qm_control.sv
module qm_control
  import qm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  input  logic        hostWrite,
  input  logic        hostPort,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        hostDone,
  input  logic        enable,
  input  logic        qEmpty,
  input  logic        qFull,
  input  logic [31:0] qHead,
  input  logic [31:0] qTail,
  output qmStrobe_t   strb,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWrData,
  input  logic [31:0] memRdData,
  input  logic        memAck
);
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_DONE} state_t;

  state_t      state;
  logic        opWr, opPort, curWr, curPort;
  logic [31:0] addrR, wdataR, rdDataR;

  assign curWr   = (state == ST_IDLE) ? hostWrite : opWr;
  assign curPort = (state == ST_IDLE) ? hostPort  : opPort;

  always_comb begin
    strb.qSel     = {curPort, curPort ? ~curWr : curWr};
    strb.setOvf   = (state == ST_IDLE) && hostValid && enable && hostWrite && qFull;
    strb.pushHead = (state == ST_MEM) && memAck && opWr;
    strb.popTail  = (state == ST_MEM) && memAck && !opWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opWr    <= 1'b0;
      opPort  <= 1'b0;
      addrR   <= '0;
      wdataR  <= '0;
      rdDataR <= '1;
    end else begin
      case (state)
        ST_IDLE: if (hostValid) begin
          opWr    <= hostWrite;
          opPort  <= hostPort;
          rdDataR <= '1;
          wdataR  <= hostWrData;
          if (!enable)                 state <= ST_DONE;
          else if (hostWrite && qFull) state <= ST_DONE;
          else if (!hostWrite && qEmpty) state <= ST_DONE;
          else begin
            addrR <= hostWrite ? qHead : qTail;
            state <= ST_MEM;
          end
        end
        ST_MEM: if (memAck) begin
          if (!opWr) rdDataR <= memRdData;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq     = (state == ST_MEM);
  assign memWe      = opWr;
  assign memAddr    = addrR;
  assign memWrData  = wdataR;
  assign hostDone   = (state == ST_DONE);
  assign hostRdData = rdDataR;
endmodule

// File: rtl/frame_queue_mgr.sv
module frame_queue_mgr
  import qm_pkg::*;
#(
  parameter int SZ_W     = 5,
  parameter int SZ_SHIFT = 11,
  parameter int BASE_LSB = 20,
  parameter int RESET_SZ = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        hostValid,
  input  logic        hostWrite,
  input  logic        hostPort,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        hostDone,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWrData,
  input  logic [31:0] memRdData,
  input  logic        memAck,
  output logic        outPostPending,
  output logic        inPostOvf,
  output logic        outFreeOvf
);
  qmStrobe_t   strb;
  logic        qEmpty, qFull, enable;
  logic [31:0] qHead, qTail, baseAddr;

  qm_datapath #(
    .SZ_W(SZ_W), .SZ_SHIFT(SZ_SHIFT), .BASE_LSB(BASE_LSB), .RESET_SZ(RESET_SZ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb),
    .qEmpty(qEmpty), .qFull(qFull), .qHead(qHead), .qTail(qTail),
    .enable(enable), .baseAddr(baseAddr), .inPostOvf(inPostOvf),
    .outFreeOvf(outFreeOvf), .outPostPending(outPostPending)
  );

  qm_control u_ctl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostPort(hostPort), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostDone(hostDone), .enable(enable), .qEmpty(qEmpty), .qFull(qFull),
    .qHead(qHead), .qTail(qTail), .strb(strb), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memAck(memAck)
  );
endmodule

// File: rtl/frame_queue_mgr_chk.sv
module frame_queue_mgr_chk #(
  parameter int BASE_LSB = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [31:0] baseAddr,
  input logic        hostValid,
  input logic        hostWrite,
  input logic        hostPort,
  input logic        hostDone,
  input logic        inPostOvf,
  input logic        outFreeOvf
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  assert_in_region_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[31:BASE_LSB] == baseAddr[31:BASE_LSB]);

  assert_in_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inPostOvf) |-> $past(hostValid && hostWrite && !hostPort));

  assert_out_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outFreeOvf) |-> $past(hostValid && hostWrite && hostPort));
endmodule

bind frame_queue_mgr frame_queue_mgr_chk #(.BASE_LSB(BASE_LSB)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .baseAddr(baseAddr), .hostValid(hostValid),
  .hostWrite(hostWrite), .hostPort(hostPort), .hostDone(hostDone),
  .inPostOvf(inPostOvf), .outFreeOvf(outFreeOvf)
);

// File: tb/frame_queue_mgr_tb.sv
module frame_queue_mgr_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        hostValid = 1'b0, hostWrite = 1'b0, hostPort = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        hostDone, memReq, memWe, memAck;
  logic [31:0] memAddr, memWrData, memRdData;
  logic        outPostPending, inPostOvf, outFreeOvf;

  logic [31:0] mem [0:4095];
  logic        bwEn = 1'b0;
  logic [11:0] bwIdx = '0;
  logic [31:0] bwData = '0;
  int          nChecks = 0, nFail = 0;

  always #5 clk = ~clk;

  frame_queue_mgr u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hostValid(hostValid),
    .hostWrite(hostWrite), .hostPort(hostPort), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostDone(hostDone), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memAck(memAck), .outPostPending(outPostPending),
    .inPostOvf(inPostOvf), .outFreeOvf(outFreeOvf)
  );

  assign memAck    = memReq;
  assign memRdData = mem[memAddr[13:2]];

  always @(posedge clk) begin
    if (bwEn) mem[bwIdx] <= bwData;
    else if (memReq && memWe) mem[memAddr[13:2]] <= memWrData;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic memPut(input logic [11:0] idx, input logic [31:0] d);
    @(negedge clk); bwEn = 1'b1; bwIdx = idx; bwData = d;
    @(negedge clk); bwEn = 1'b0;
  endtask

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdData;
  endtask

  task automatic hostOp(input bit wr, input bit port, input logic [31:0] d, output logic [31:0] rd);
    int guard;
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostPort = port; hostWrData = d;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!hostDone && guard < 50);
    rd = hostRdData;
    check(hostDone === 1'b1, "R11 hostDone seen", 32'(hostDone), 32'd1);
    hostValid = 1'b0;
    @(negedge clk);
    chkEq("R11 hostDone one cycle", 32'(hostDone), 32'd0);
  endtask

  // {write, port, wdata, expected read data}
  localparam logic [65:0] VEC [6] = '{
    {1'b0, 1'b0, 32'h0, 32'hA000_0100},   // R4 inbound pop 1
    {1'b0, 1'b0, 32'h0, 32'hA000_0200},   // R4 inbound pop 2
    {1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF},   // R7 inbound free now empty
    {1'b1, 1'b0, 32'hC0DE_0001, 32'h0},   // R5 inbound push
    {1'b1, 1'b1, 32'hD00D_0002, 32'h0},   // R6 outbound push
    {1'b0, 1'b1, 32'h0, 32'hFFFF_FFFF}    // R7 outbound post empty
  };

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nChecks, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h5A5A_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state R2
    regRd(4'd1, r);  chkEq("R2 ctrl reset", r, 32'h2);
    regRd(4'd2, r);  chkEq("R2 in-free head reset", r, 32'h0);
    regRd(4'd4, r);  chkEq("R2 in-post head reset", r, 32'h800);
    regRd(4'd7, r);  chkEq("R2 out-free tail reset", r, 32'h1000);
    regRd(4'd9, r);  chkEq("R2 out-post tail reset", r, 32'h1800);
    chkEq("R10 pending after reset", 32'(outPostPending), 32'd0);

    // Disabled R9
    hostOp(1'b1, 1'b0, 32'h1111_1111, r);
    regRd(4'd4, r);  chkEq("R9 disabled write ignored", r, 32'h800);
    chkEq("R9 disabled write no mem", mem[12'h200], 32'h5A5A_0200);
    memPut(12'h0, 32'hA000_0100);
    regWr(4'd2, 32'h4);
    hostOp(1'b0, 1'b0, 32'h0, r);
    chkEq("R9 disabled read all ones", r, 32'hFFFF_FFFF);
    regRd(4'd3, r);  chkEq("R9 disabled read tail kept", r, 32'h0);

    // Enable and preload inbound free (R12 pointer write)
    regWr(4'd1, 32'h3);
    memPut(12'h1, 32'hA000_0200);
    regWr(4'd2, 32'h8);
    regRd(4'd2, r);  chkEq("R12 pointer readback", r, 32'h8);

    for (int v = 0; v < 6; v++) begin
      hostOp(VEC[v][65], VEC[v][64], VEC[v][63:32], r);
      if (!VEC[v][65]) chkEq($sformatf("R4/R6/R7 vector %0d read", v), r, VEC[v][31:0]);
    end
    regRd(4'd3, r);  chkEq("R7 in-free tail after empty read", r, 32'h8);
    chkEq("R5 pushed word", mem[12'h200], 32'hC0DE_0001);
    regRd(4'd4, r);  chkEq("R5 in-post head", r, 32'h804);
    chkEq("R6 outbound push word", mem[12'h400], 32'hD00D_0002);
    regRd(4'd6, r);  chkEq("R6 out-free head", r, 32'h1004);

    // Outbound post pop R6 R10
    memPut(12'h600, 32'hE000_0003);
    regWr(4'd8, 32'h1804);
    chkEq("R10 pending set", 32'(outPostPending), 32'd1);
    hostOp(1'b0, 1'b1, 32'h0, r);
    chkEq("R6 outbound pop data", r, 32'hE000_0003);
    chkEq("R10 pending cleared", 32'(outPostPending), 32'd0);
    regRd(4'd9, r);  chkEq("R6 out-post tail", r, 32'h1804);

    // Wrap R3
    regWr(4'd4, 32'hFFC);
    regWr(4'd5, 32'hFFC);
    hostOp(1'b1, 1'b0, 32'hF00D_0004, r);
    chkEq("R3 last entry written", mem[12'h3FF], 32'hF00D_0004);
    regRd(4'd4, r);  chkEq("R3 head wrapped", r, 32'h800);

    // Full R8
    regWr(4'd4, 32'h804);
    regWr(4'd5, 32'h808);
    hostOp(1'b1, 1'b0, 32'hBAD0_0005, r);
    regRd(4'd4, r);  chkEq("R8 full head kept", r, 32'h804);
    chkEq("R8 full no write", mem[12'h201], 32'h5A5A_0201);
    chkEq("R8 inPostOvf set", 32'(inPostOvf), 32'd1);
    chkEq("R8 outFreeOvf clear", 32'(outFreeOvf), 32'd0);
    regWr(4'd6, 32'h1004);
    regWr(4'd7, 32'h1008);
    hostOp(1'b1, 1'b1, 32'hBAD0_0006, r);
    chkEq("R8 outFreeOvf set", 32'(outFreeOvf), 32'd1);
    chkEq("R8 inPostOvf sticky", 32'(inPostOvf), 32'd1);
    regWr(4'd1, 32'h3);
    chkEq("R8 ovf cleared by ctrl write", 32'({inPostOvf, outFreeOvf}), 32'd0);
    regRd(4'd7, r);  chkEq("R2 same-size ctrl keeps pointers", r, 32'h1008);

    // Size change R2
    regWr(4'd1, 32'h5);
    regRd(4'd4, r);  chkEq("R2 size 2 in-post start", r, 32'h1000);
    regRd(4'd9, r);  chkEq("R2 size 2 out-post start", r, 32'h3000);

    // Base alignment R1
    regWr(4'd0, 32'h1234_5678);
    regRd(4'd0, r);  chkEq("R1 base low bits zero", r, 32'h1230_0000);
    regRd(4'd3, r);  chkEq("R1 R2 in-free tail at base", r, 32'h1230_0000);
    regRd(4'd6, r);  chkEq("R2 out-free head at base", r, 32'h1230_2000);
    hostOp(1'b0, 1'b0, 32'h0, r);
    chkEq("R7 empty after base write", r, 32'hFFFF_FFFF);
    memPut(12'h0, 32'h7777_0007);
    regWr(4'd2, 32'h1230_0004);
    hostOp(1'b0, 1'b0, 32'h0, r);
    chkEq("R1 pop from based region", r, 32'h7777_0007);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule